// File: doc/BRIEF.md
# Sensorless Six-Step Brushless Motor Commutator

This block sequences the three half-bridges of a star-wound brushless DC motor through the six drive states of one electrical revolution. In every state one terminal is pulled high, one is pulled low and the third floats; the block names the floating terminal so that an external multiplexer can route its back-EMF comparator to the single comparator input. Each state lasts a commutation interval held in a register, and a PWM input gates all bridge enables.

The interval adapts on its own. Inside each state the block times the first valid change of the comparator output, measured from the start of that state. At the next state change it loads twice that time, clamped to a programmable window. A crossing in the middle of the state leaves the interval unchanged. An early crossing shortens it and a late one lengthens it. A state with no valid crossing keeps the old interval and bumps a saturating miss counter. Comparator changes just after a state change are masked out, since switching ringing shows up there.

Top module: `bldc_commutator`

## Requirements
- R1: During reset (rst_n low at a clock edge) the state index returns to 0, the interval loads `interval_max`, the miss counter clears, and with `enable` low all six bridge enables are 0.
- R2: The state index selects the drive, with bit 0 = phase A, bit 1 = phase B and bit 2 = phase C in `hi_en`/`lo_en`, and `sense_sel` coding the floating phase as 0 = A, 1 = B, 2 = C. The six states are: state 0 hi=001 lo=010 sense=2; state 1 hi=001 lo=100 sense=1; state 2 hi=010 lo=100 sense=0; state 3 hi=010 lo=001 sense=2; state 4 hi=100 lo=001 sense=1; state 5 hi=100 lo=010 sense=0.
- R3: When `pwm_on` or `enable` is low, all six bridge enables are 0 in that same cycle.
- R4: No phase ever has its high-side and low-side enable asserted together.
- R5: While enabled, each state lasts exactly `interval` clock cycles (the value held when the state began). The index then advances by one and wraps from 5 to 0.
- R6: A state with a valid crossing seen at cycle offset t (0 = first cycle of the state) ends by loading 2*t into `interval`, raised to `interval_min` or lowered to `interval_max` if outside that window.
- R7: Only the first valid comparator change in a state is timed. Later changes in the same state are ignored.
- R8: A comparator change is invalid when it falls at an offset below `MASK_CYC` (default 4) or in the final cycle of the state.
- R9: A state with no valid crossing leaves `interval` unchanged and increments `miss_count`, which saturates at its all-ones value.
- R10: With `enable` low, the state index is held at 0 and the state timer restarts from offset 0 when `enable` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the sequence. Low holds state 0 and turns drive off |
| pwm_on | input | 1 | PWM duty phase. Low turns all bridge enables off |
| bemf_cmp | input | 1 | Synchronized comparator output for the floating phase |
| interval_min | input | CNT_W | Lower clamp for the commutation interval |
| interval_max | input | CNT_W | Upper clamp. Also the interval after reset |
| hi_en | output | 3 | High-side enables, bit 0 = A, 1 = B, 2 = C |
| lo_en | output | 3 | Low-side enables, same bit order |
| sense_sel | output | 2 | Floating phase to sense: 0 = A, 1 = B, 2 = C |
| step | output | 3 | Current state index 0..5 |
| interval | output | CNT_W | Commutation interval in clock cycles |
| miss_count | output | ERR_W | Saturating count of states without a valid crossing |

## Verification
A corrupted state timer shows up on `step` within one interval as a state that is one cycle too long or too short. A wrong captured crossing time appears on `interval` at the very next state change, as a value that is not twice the stimulus offset or is not clamped. A bad masking decision shows on `interval` and on `miss_count` at the end of the state that held the edge. A bad decode shows on `hi_en`, `lo_en` and `sense_sel` in the first cycle of the wrong state.

// File: rtl/bldc_pkg.sv
// Shared types and the drive decode table for the six-step commutator.
// Assumes phase order A=bit0, B=bit1, C=bit2.
package bldc_pkg;
    localparam int NUM_STEPS = 6;

    typedef logic [2:0] step_t;

    typedef struct packed {
        logic [2:0] hi;
        logic [2:0] lo;
        logic [1:0] sense;
    } drive_t;

    // Map a state index to its high side, low side and floating phase.
    function automatic drive_t drive_for(step_t s);
        drive_t d;
        case (s)
            3'd0:    d = '{hi: 3'b001, lo: 3'b010, sense: 2'd2};
            3'd1:    d = '{hi: 3'b001, lo: 3'b100, sense: 2'd1};
            3'd2:    d = '{hi: 3'b010, lo: 3'b100, sense: 2'd0};
            3'd3:    d = '{hi: 3'b010, lo: 3'b001, sense: 2'd2};
            3'd4:    d = '{hi: 3'b100, lo: 3'b001, sense: 2'd1};
            3'd5:    d = '{hi: 3'b100, lo: 3'b010, sense: 2'd0};
            default: d = '{hi: 3'b000, lo: 3'b000, sense: 2'd0};
        endcase
        return d;
    endfunction
endpackage

// File: rtl/bldc_step_timer.sv
// State timer and six-state sequencer.
// Counts cycles within a state and advances the index when the count
// reaches the current interval. Assumes interval >= 1 in normal use.
module bldc_step_timer
    import bldc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] interval,
    output logic [CNT_W-1:0] timer,
    output step_t            step,
    output logic             adv
);
    localparam step_t LAST_STEP = step_t'(NUM_STEPS - 1);

    logic [CNT_W:0] timer_next;

    // Offset the state will have in the next cycle, one bit wider to avoid wrap.
    always_comb begin
        timer_next = {1'b0, timer} + {{CNT_W{1'b0}}, 1'b1};
        adv        = enable && (timer_next >= {1'b0, interval});
    end

    // Advance the offset counter and the state index.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            timer <= '0;
            step  <= '0;
        end else if (adv) begin
            timer <= '0;
            step  <= (step == LAST_STEP) ? step_t'(0) : step + step_t'(1);
        end else begin
            timer <= timer_next[CNT_W-1:0];
        end
    end

    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        step <= LAST_STEP);                                              // R5
    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && step == LAST_STEP) |=> (step == step_t'(0)));            // R5
    AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !adv) |=> $stable(step));                             // R5
endmodule

// File: rtl/bldc_zc_capture.sv
// Zero-crossing timer for the floating phase.
// Records the state offset of the first valid comparator change in each
// state. Assumes bemf_cmp is already synchronized to clk.
module bldc_zc_capture #(
    parameter int CNT_W    = 16,
    parameter int MASK_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             bemf_cmp,
    input  logic [CNT_W-1:0] timer,
    input  logic             adv,
    output logic             zc_seen,
    output logic [CNT_W-1:0] zc_time
);
    localparam logic [CNT_W-1:0] MASK_LIM = CNT_W'(MASK_CYC);

    logic cmp_q;
    logic edge_ok;

    // Accept a change only outside the blanking window, not in the last cycle.
    always_comb begin
        edge_ok = enable && !adv && !zc_seen
               && (bemf_cmp != cmp_q) && (timer >= MASK_LIM);
    end

    // Previous comparator level for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cmp_q <= 1'b0;
        else        cmp_q <= bemf_cmp;
    end

    // Latch the first accepted crossing; clear at every state boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zc_seen <= 1'b0;
            zc_time <= '0;
        end else if (!enable || adv) begin
            zc_seen <= 1'b0;
        end else if (edge_ok) begin
            zc_seen <= 1'b1;
            zc_time <= timer;
        end
    end

    AST_MASK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zc_seen) |-> ($past(timer) >= MASK_LIM));                  // R8
    AST_FIRST_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (zc_seen && enable) |=> $stable(zc_time));                       // R7
endmodule

// File: rtl/bldc_interval_ctrl.sv
// Commutation interval update and missed-crossing counter.
// At each state boundary loads twice the crossing time, clamped to
// [interval_min, interval_max], or keeps the interval on a miss.
// Assumes interval_min <= interval_max.
module bldc_interval_ctrl #(
    parameter int CNT_W = 16,
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             zc_seen,
    input  logic [CNT_W-1:0] zc_time,
    input  logic [CNT_W-1:0] interval_min,
    input  logic [CNT_W-1:0] interval_max,
    output logic [CNT_W-1:0] interval,
    output logic [ERR_W-1:0] miss_count
);
    localparam logic [ERR_W-1:0] MISS_SAT = '1;

    logic [CNT_W:0]   doubled;
    logic [CNT_W-1:0] clamped;

    // Twice the crossing offset, pulled into the programmed window.
    always_comb begin
        doubled = {zc_time, 1'b0};
        if (doubled < {1'b0, interval_min})      clamped = interval_min;
        else if (doubled > {1'b0, interval_max}) clamped = interval_max;
        else                                      clamped = doubled[CNT_W-1:0];
    end

    // Update interval or count a miss at each state boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            interval   <= interval_max;
            miss_count <= '0;
        end else if (adv) begin
            if (zc_seen)                     interval   <= clamped;
            else if (miss_count != MISS_SAT) miss_count <= miss_count + 1'b1;
        end
    end

    AST_CLAMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && zc_seen) |=> (interval >= $past(interval_min)
                           && interval <= $past(interval_max)));        // R6
    AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !zc_seen) |=> $stable(interval));                        // R9
    AST_MISS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !zc_seen && miss_count != MISS_SAT)
            |=> (miss_count == $past(miss_count) + 1'b1));               // R9
endmodule

// File: rtl/bldc_commutator.sv
// Sensorless six-step commutator top level.
// Ties the state timer, crossing capture and interval control together and
// gates the decoded bridge enables with enable and pwm_on.
// Assumes the caller routes the phase named by sense_sel to bemf_cmp.
module bldc_commutator
    import bldc_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int MASK_CYC = 4,
    parameter int ERR_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             pwm_on,
    input  logic             bemf_cmp,
    input  logic [CNT_W-1:0] interval_min,
    input  logic [CNT_W-1:0] interval_max,
    output logic [2:0]       hi_en,
    output logic [2:0]       lo_en,
    output logic [1:0]       sense_sel,
    output logic [2:0]       step,
    output logic [CNT_W-1:0] interval,
    output logic [ERR_W-1:0] miss_count
);
    logic [CNT_W-1:0] timer;
    logic             adv;
    logic             zc_seen;
    logic [CNT_W-1:0] zc_time;
    drive_t           drv;

    bldc_step_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .interval (interval),
        .timer    (timer),
        .step     (step),
        .adv      (adv)
    );

    bldc_zc_capture #(.CNT_W(CNT_W), .MASK_CYC(MASK_CYC)) u_zc (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .bemf_cmp (bemf_cmp),
        .timer    (timer),
        .adv      (adv),
        .zc_seen  (zc_seen),
        .zc_time  (zc_time)
    );

    bldc_interval_ctrl #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_ival (
        .clk          (clk),
        .rst_n        (rst_n),
        .adv          (adv),
        .zc_seen      (zc_seen),
        .zc_time      (zc_time),
        .interval_min (interval_min),
        .interval_max (interval_max),
        .interval     (interval),
        .miss_count   (miss_count)
    );

    // Decode the state and gate the bridges with run and duty.
    always_comb begin
        drv       = drive_for(step);
        sense_sel = drv.sense;
        hi_en     = (enable && pwm_on) ? drv.hi : 3'b000;
        lo_en     = (enable && pwm_on) ? drv.lo : 3'b000;
    end

    AST_NO_SHOOT_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_en & lo_en) == 3'b000);                                      // R4
    AST_PWM_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_on || !enable) |-> (hi_en == 3'b000 && lo_en == 3'b000));  // R3
    AST_ONE_PER_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hi_en) && $onehot0(lo_en));                             // R2
endmodule

// File: tb/bldc_commutator_test.sv
// Self-checking bench: a vector table of crossing offsets walked state by
// state, then directed tests for saturation, gating, enable and reset.
module bldc_commutator_test;
    localparam int CNT_W = 16;
    localparam int ERR_W = 8;
    localparam int NONE  = -1;
    localparam int NV    = 11;
    // min, max, first edge offset, second edge offset, expected new interval, miss increment
    localparam int VEC [NV][6] = '{
        '{ 8, 40, 10, NONE, 20, 0},   // R6 early crossing shortens
        '{ 8, 40,  9, NONE, 18, 0},   // R6
        '{ 8, 40, 12, NONE, 24, 0},   // R6 late crossing lengthens
        '{ 8, 40,  2, NONE, 24, 1},   // R8 masked edge -> miss
        '{ 8, 40, NONE, NONE, 24, 1}, // R9 no edge
        '{30, 40, 10, NONE, 30, 0},   // R6 clamp to min
        '{ 8, 40, 25, NONE, 40, 0},   // R6 clamp to max
        '{ 8, 40,  4, NONE,  8, 0},   // R8 first unmasked offset
        '{ 8, 40,  2,    5, 10, 0},   // R8 masked then valid
        '{ 8, 40,  5,    7, 10, 0},   // R7 second edge ignored
        '{ 8, 40,  9, NONE, 10, 1}    // R8 edge in final cycle ignored
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic pwm_on = 1'b0;
    logic bemf_cmp = 1'b0;
    logic [CNT_W-1:0] interval_min = 16'd8;
    logic [CNT_W-1:0] interval_max = 16'd40;
    logic [2:0] hi_en, lo_en, step;
    logic [1:0] sense_sel;
    logic [CNT_W-1:0] interval;
    logic [ERR_W-1:0] miss_count;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_int;
    int exp_miss;
    int exp_step;

    always #2 clk = ~clk;

    bldc_commutator uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .pwm_on(pwm_on),
        .bemf_cmp(bemf_cmp), .interval_min(interval_min),
        .interval_max(interval_max), .hi_en(hi_en), .lo_en(lo_en),
        .sense_sel(sense_sel), .step(step), .interval(interval),
        .miss_count(miss_count)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    // Expected {hi, lo, sense} written from the requirement table.
    function automatic logic [7:0] exp_drive(input int s);
        case (s)
            0: return {3'b001, 3'b010, 2'd2};
            1: return {3'b001, 3'b100, 2'd1};
            2: return {3'b010, 3'b100, 2'd0};
            3: return {3'b010, 3'b001, 2'd2};
            4: return {3'b100, 3'b001, 2'd1};
            default: return {3'b100, 3'b010, 2'd0};
        endcase
    endfunction

    task automatic check_drive();
        logic [7:0] e;
        e = exp_drive(exp_step);
        check(step == 3'(exp_step), "R5 step index", int'(step), exp_step);
        check({hi_en, lo_en, sense_sel} == e, "R2 drive decode",
              int'({hi_en, lo_en, sense_sel}), int'(e));
        check((hi_en & lo_en) == 3'b000, "R4 no shoot-through", int'(hi_en & lo_en), 0);
    endtask

    // Run one state from its first cycle; toggle the comparator at given offsets.
    task automatic run_state(input int d1, input int d2, output int len);
        logic [2:0] s0;
        s0  = step;
        len = 0;
        while (len < 1000) begin
            if (len == d1) bemf_cmp = ~bemf_cmp;
            if (len == d2) bemf_cmp = ~bemf_cmp;
            @(negedge clk);
            len++;
            if (step != s0) break;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        int len;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(step == 3'd0, "R1 step after reset", int'(step), 0);
        check(interval == 16'd40, "R1 interval after reset", int'(interval), 40);
        check(miss_count == '0, "R1 miss after reset", int'(miss_count), 0);
        check(hi_en == 3'b000 && lo_en == 3'b000, "R1 drive off", int'({hi_en, lo_en}), 0);

        pwm_on   = 1'b1;
        enable   = 1'b1;
        exp_int  = 40;
        exp_miss = 0;
        exp_step = 0;
        @(negedge clk);
        // R10 timer restarts: one cycle of state 0 already elapsed
        check_drive();
        run_state(NONE, NONE, len);
        check(len + 1 == exp_int, "R10 first state length", len + 1, exp_int);
        exp_miss++;
        exp_step = 1;
        check_drive();

        for (int v = 0; v < NV; v++) begin
            interval_min = 16'(VEC[v][0]);
            interval_max = 16'(VEC[v][1]);
            run_state(VEC[v][2], VEC[v][3], len);
            check(len == exp_int, "R5 state length", len, exp_int);
            exp_int  = VEC[v][4];
            exp_miss = exp_miss + VEC[v][5];
            exp_step = (exp_step + 1) % 6;
            check(int'(interval) == exp_int, "R6 new interval", int'(interval), exp_int);
            check(int'(miss_count) == exp_miss, "R9 miss count", int'(miss_count), exp_miss);
            check_drive();
        end

        // R9 saturation: no crossings for many states
        interval_min = 16'd8;
        interval_max = 16'd8;
        for (int k = 0; k < 260; k++) begin
            run_state(NONE, NONE, len);
            if (k == 0) begin
                check(len == exp_int, "R9 interval held", len, exp_int);
            end
            exp_step = (exp_step + 1) % 6;
        end
        check(miss_count == 8'hFF, "R9 miss saturates", int'(miss_count), 255);
        check(interval == 16'd10, "R9 interval kept on miss", int'(interval), 10);
        check_drive();

        // R3 duty gating
        pwm_on = 1'b0;
        #1;
        check(hi_en == 3'b000 && lo_en == 3'b000, "R3 pwm off", int'({hi_en, lo_en}), 0);
        pwm_on = 1'b1;
        #1;
        check(hi_en != 3'b000, "R3 pwm back on", int'(hi_en), 1);

        // R10 enable low holds state 0
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(step == 3'd0, "R10 step held at 0", int'(step), 0);
        check(hi_en == 3'b000 && lo_en == 3'b000, "R3 enable off", int'({hi_en, lo_en}), 0);

        // R1 reset again clears miss counter and reloads interval
        interval_max = 16'd33;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(miss_count == '0, "R1 miss cleared", int'(miss_count), 0);
        check(interval == 16'd33, "R1 interval reload", int'(interval), 33);
        summary();
    end
endmodule